// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing protocol engine of a small serial EEPROM of 2, 4, 8 or 16 Kbit, organised as 256-byte blocks. It runs on a fast system clock and oversamples the two bus lines through a synchroniser. It finds start and stop conditions, receives and matches the device address byte, and acknowledges by pulling the data line low. After a match it either takes a word address and data bytes for a write, or shifts data bytes out for a read. Depending on the configured size, the three low address bits either select a 256-byte block or are compared against strap pins.

Downstream, every received data byte goes to a page buffer as a single-cycle write strobe carrying the target address. A stop that follows at least one data byte raises a one-cycle commit pulse, which starts the internal programming cycle. The array reports that cycle back on a busy input. While busy is high the engine stays silent, so a master can poll for completion by repeatedly addressing the device. Reads use an asynchronous array port: the engine presents a byte address and samples the returned byte in the same cycle.

Top module: `twi_eeprom_slave`

## Requirements
- R1: The engine acknowledges an address byte only when its bits [7:4] equal 4'b1010. Any other value leaves SDA released, and the engine stays idle until the next start.
- R2: Address byte bits [3:1] are handled according to MEM_KBIT. At 2 Kbit all three must equal strap_i[2:0]. At 4 Kbit bit 1 selects the block and bits [3:2] must equal strap_i[2:1]. At 8 Kbit bits [2:1] select the block and bit 3 must equal strap_i[2]. At 16 Kbit all three select the block. Block bits form the word-address bits above bit 7.
- R3: While busy_i is high, an address byte that would otherwise match gets no acknowledge. This includes polling with the write direction.
- R4: sda_pull_o (1 = drive SDA low, 0 = release) changes only while the synchronised SCL is low, outside start and stop. It is asserted throughout the ninth clock of every byte the engine acknowledges.
- R5: In a write (address bit 0 = 0), the first byte after the address byte loads the word pointer. Each later byte pulses wr_en_o for one cycle, with wr_addr_o equal to the pointer and wr_data_o equal to the byte, and is acknowledged.
- R6: After each written byte, pointer bits [3:0] increment and wrap within the 16-byte page, while the upper bits stay the same.
- R7: commit_o pulses for one cycle at a stop that follows at least one data byte. A stop with no data byte, or a repeated start, produces no pulse.
- R8: In a read (address bit 0 = 1), the byte at the pointer is sent MSB first, and the pointer then increments, wrapping across the whole array. A master acknowledge sends the next byte. A master non-acknowledge releases SDA and ends the read. A read with no word address starts at the current pointer.
- R9: A start at any point, including in the middle of a byte, abandons the transfer and begins reception of a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| strap_i | input | 3 | Chip-select strap pins, bit i compared with address bit i+1 |
| busy_i | input | 1 | Internal programming cycle in progress |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en_o | output | 1 | One-cycle strobe of a received data byte to the page buffer |
| wr_addr_o | output | ADDR_W | Array address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | One-cycle pulse starting the programming cycle |
| rd_addr_o | output | ADDR_W | Read pointer to the array port |
| rd_data_i | input | 8 | Array byte at rd_addr_o, same cycle |

## Verification
The bench puts two instances on one wired-AND bus. One is built at 2 Kbit with straps 3'b101, where all three address bits are compared. The other is built at 4 Kbit with straps 3'b110, where one address bit is a block select. This makes it possible to check that exactly one device answers each address, that a strap mismatch is rejected, and that a block-select bit reaches the ninth word-address bit. Read-pointer wrap is checked at the 256-byte array end, and page wrap is checked with a 20-byte burst. The 8 and 16 Kbit variants use the same generate path with more block bits, but no bench instance is built with those values.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_WORD, S_DATA, S_SACK, S_TX, S_MACK
  } twi_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  function automatic int blk_bits(input int kbit);
    return (kbit >= 16) ? 3 : (kbit >= 8) ? 2 : (kbit >= 4) ? 1 : 0;
  endfunction
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[0] <= '1;
        else         stg[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= '1;
        else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/twi_line_mon.sv
module twi_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_prev_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] s;
  logic       scl_q, sda_q;

  twi_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= s[1];
      sda_q <= s[0];
    end

  assign scl_o      = s[1];
  assign sda_o      = s[0];
  assign scl_prev_o = scl_q;
  assign scl_rise_o = s[1] & ~scl_q;
  assign scl_fall_o = ~s[1] & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = s[1] & scl_q & sda_q & ~s[0];
  assign stop_o     = s[1] & scl_q & ~sda_q & s[0];
endmodule

// File: rtl/twi_addr_match.sv
module twi_addr_match
  import twi_eep_pkg::*;
#(
  parameter int BLK_W = 0
) (
  input  logic [7:1] dev_i,
  input  logic [2:0] strap_i,
  output logic       hit_o,
  output logic [2:0] blk_o
);
  logic [2:0] eq;

  for (genvar i = 0; i < 3; i++) begin : g_bit
    localparam bit IS_BLK = (i < BLK_W);
    assign eq[i]    = IS_BLK | (dev_i[i+1] == strap_i[i]);
    assign blk_o[i] = IS_BLK & dev_i[i+1];
  end

  assign hit_o = (dev_i[7:4] == DEV_TYPE) & (&eq);
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eep_pkg::*;
#(
  parameter int MEM_KBIT    = 2,
  parameter int PAGE_BYTES  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(MEM_KBIT * 128),
  localparam int BLK_W      = blk_bits(MEM_KBIT),
  localparam int PG_W       = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam logic [ADDR_W-1:0] PG_MASK = ADDR_W'(PAGE_BYTES - 1);

  logic scl_s, sda_s, scl_prev, scl_rise, scl_fall, start_w, stop_w;
  logic hit;
  logic [2:0] blk;

  twi_state_e        st_q, ret_q;
  logic [2:0]        cnt_q;
  logic [6:0]        sr_q;
  logic              ack_ph_q, pend_q, mnack_q, pull_q;
  logic [2:0]        blk_q;
  logic [ADDR_W-1:0] ptr_q, wr_addr_q;
  logic [7:0]        wr_data_q;
  logic              wr_en_q, commit_q;
  logic [7:0]        rx_byte;
  logic [ADDR_W-1:0] ptr_pg_inc;

  twi_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_prev_o(scl_prev),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_w),
    .stop_o    (stop_w)
  );

  assign rx_byte = {sr_q, sda_s};

  twi_addr_match #(.BLK_W(BLK_W)) u_match (
    .dev_i  (rx_byte[7:1]),
    .strap_i(strap_i),
    .hit_o  (hit),
    .blk_o  (blk)
  );

  assign ptr_pg_inc = (ptr_q & ~PG_MASK) | ((ptr_q + 1'b1) & PG_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      ret_q     <= S_IDLE;
      cnt_q     <= '0;
      sr_q      <= '0;
      ack_ph_q  <= 1'b0;
      pend_q    <= 1'b0;
      mnack_q   <= 1'b0;
      pull_q    <= 1'b0;
      blk_q     <= '0;
      ptr_q     <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_en_q   <= 1'b0;
      commit_q  <= 1'b0;
    end else begin
      wr_en_q  <= 1'b0;
      commit_q <= 1'b0;
      if (start_w) begin
        st_q   <= S_DEV;
        cnt_q  <= '0;
        pull_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (stop_w) begin
        st_q     <= S_IDLE;
        pull_q   <= 1'b0;
        commit_q <= pend_q;
        pend_q   <= 1'b0;
      end else begin
        unique case (st_q)
          S_DEV, S_WORD, S_DATA: begin
            if (scl_rise) begin
              sr_q  <= rx_byte[6:0];
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == 3'd7) begin
                ack_ph_q <= 1'b0;
                if (st_q == S_DEV) begin
                  if (hit && !busy_i) begin
                    st_q  <= S_SACK;
                    ret_q <= rx_byte[0] ? S_TX : S_WORD;
                    blk_q <= blk;
                  end else begin
                    st_q <= S_IDLE;
                  end
                end else if (st_q == S_WORD) begin
                  st_q  <= S_SACK;
                  ret_q <= S_DATA;
                  ptr_q <= ADDR_W'({blk_q, rx_byte});
                end else begin
                  st_q      <= S_SACK;
                  ret_q     <= S_DATA;
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= ptr_q;
                  wr_data_q <= rx_byte;
                  ptr_q     <= ptr_pg_inc;
                  pend_q    <= 1'b1;
                end
              end
            end
          end
          S_SACK: begin
            if (scl_fall) begin
              if (!ack_ph_q) begin
                pull_q   <= 1'b1;   // ninth clock low phase
                ack_ph_q <= 1'b1;
              end else begin
                cnt_q <= '0;
                st_q  <= ret_q;
                if (ret_q == S_TX) begin
                  sr_q   <= rd_data_i[6:0];
                  pull_q <= ~rd_data_i[7];
                  ptr_q  <= ptr_q + 1'b1;
                end else begin
                  pull_q <= 1'b0;
                end
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == 3'd7) begin
                pull_q <= 1'b0;
                st_q   <= S_MACK;
              end else begin
                pull_q <= ~sr_q[6];
                sr_q   <= {sr_q[5:0], 1'b0};
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mnack_q <= sda_s;
            end else if (scl_fall) begin
              if (mnack_q) begin
                st_q <= S_IDLE;
              end else begin
                sr_q   <= rd_data_i[6:0];
                pull_q <= ~rd_data_i[7];
                ptr_q  <= ptr_q + 1'b1;
                cnt_q  <= '0;
                st_q   <= S_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_en_o    = wr_en_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign commit_o   = commit_q;
  assign rd_addr_o  = ptr_q;
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk
  import twi_eep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PG_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              scl_prev,
  input logic              start_w,
  input logic              stop_w,
  input logic              busy_i,
  input twi_state_e        st_q,
  input logic              sda_pull_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              commit_o
);
  logic [ADDR_W-1:0] last_q;
  logic              have_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      last_q <= '0;
      have_q <= 1'b0;
    end else if (start_w) begin
      have_q <= 1'b0;
    end else if (wr_en_o) begin
      last_q <= wr_addr_o;
      have_q <= 1'b1;
    end

  p_sda_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && scl_prev && !start_w && !stop_w) |=> $stable(sda_pull_o));

  p_busy_no_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_i) && $past(st_q) == S_DEV) |-> (st_q != S_SACK));

  p_commit_at_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_w));

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_o, commit_o}));

  p_page_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && have_q) |->
      (wr_addr_o[ADDR_W-1:PG_W] == last_q[ADDR_W-1:PG_W]) &&
      (wr_addr_o[PG_W-1:0] == PG_W'(last_q[PG_W-1:0] + 1'b1)));
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .scl_prev  (scl_prev),
  .start_w   (start_w),
  .stop_w    (stop_w),
  .busy_i    (busy_i),
  .st_q      (st_q),
  .sda_pull_o(sda_pull_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .commit_o  (commit_o)
);

// File: tb/tb_twi_eeprom_slave.sv
module tb_eep_model #(
  parameter int AW       = 8,
  parameter int BUSY_CYC = 400
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output int            commits
);
  logic [7:0]    mem [1<<AW];
  logic          stg_v [16];
  logic [AW-1:0] stg_a [16];
  logic [7:0]    stg_d [16];
  int            bcnt;

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 16; i++) stg_v[i] = 1'b0;
    bcnt = 0;
    commits = 0;
  end

  always @(posedge clk) begin
    if (wr_en) begin
      stg_v[wr_addr[3:0]] = 1'b1;
      stg_a[wr_addr[3:0]] = wr_addr;
      stg_d[wr_addr[3:0]] = wr_data;
    end
    if (commit) begin
      for (int k = 0; k < 16; k++) begin
        if (stg_v[k]) mem[stg_a[k]] = stg_d[k];
        stg_v[k] = 1'b0;
      end
      commits = commits + 1;
      bcnt = BUSY_CYC;
    end else if (bcnt > 0) begin
      bcnt = bcnt - 1;
    end
  end

  assign busy    = (bcnt > 0);
  assign rd_data = mem[rd_addr];
endmodule

module tb_twi_eeprom_slave;
  localparam int Q        = 8;
  localparam int BUSY_CYC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic pull_a, pull_b;
  wire  bus_sda = m_sda & ~pull_a & ~pull_b;

  logic       wen_a, com_a, busy_a, wen_b, com_b, busy_b;
  logic [7:0] wad_a, rad_a, wdt_a, rdt_a, wdt_b, rdt_b;
  logic [8:0] wad_b, rad_b;
  int         cm_a, cm_b;

  int checks = 0, fails = 0;
  logic [7:0] exp_m [2][512];

  always #5 clk = ~clk;

  twi_eeprom_slave #(.MEM_KBIT(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .strap_i(3'b101), .busy_i(busy_a), .sda_pull_o(pull_a),
    .wr_en_o(wen_a), .wr_addr_o(wad_a), .wr_data_o(wdt_a),
    .commit_o(com_a), .rd_addr_o(rad_a), .rd_data_i(rdt_a));

  twi_eeprom_slave #(.MEM_KBIT(4)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .strap_i(3'b110), .busy_i(busy_b), .sda_pull_o(pull_b),
    .wr_en_o(wen_b), .wr_addr_o(wad_b), .wr_data_o(wdt_b),
    .commit_o(com_b), .rd_addr_o(rad_b), .rd_data_i(rdt_b));

  tb_eep_model #(.AW(8), .BUSY_CYC(BUSY_CYC)) u_mem_a (
    .clk(clk), .wr_en(wen_a), .wr_addr(wad_a), .wr_data(wdt_a), .commit(com_a),
    .rd_addr(rad_a), .rd_data(rdt_a), .busy(busy_a), .commits(cm_a));

  tb_eep_model #(.AW(9), .BUSY_CYC(BUSY_CYC)) u_mem_b (
    .clk(clk), .wr_en(wen_b), .wr_addr(wad_b), .wr_data(wdt_b), .commit(com_b),
    .rd_addr(rad_b), .rd_data(rdt_b), .busy(busy_b), .commits(cm_b));

  function automatic int dsize(input int d);
    return (d == 0) ? 256 : 512;
  endfunction

  function automatic logic [7:0] dev_byte(input int d, input int a, input bit rw);
    if (d == 0) return {4'b1010, 3'b101, rw};
    return {4'b1010, 2'b11, a[8], rw};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input bit b);
    m_sda = b; hq(Q); m_scl = 1'b1; hq(2*Q); m_scl = 1'b0; hq(Q);
  endtask

  task automatic bit_in(output bit b);
    m_sda = 1'b1; hq(Q); m_scl = 1'b1; hq(Q); b = bus_sda; hq(Q); m_scl = 1'b0; hq(Q);
  endtask

  task automatic do_start;
    m_sda = 1'b1; hq(Q); m_scl = 1'b1; hq(Q); m_sda = 1'b0; hq(Q); m_scl = 1'b0; hq(Q);
  endtask

  task automatic do_stop;
    m_sda = 1'b0; hq(Q); m_scl = 1'b1; hq(Q); m_sda = 1'b1; hq(2*Q);
  endtask

  task automatic send(input logic [7:0] v, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic recv(output logic [7:0] v, input bit nack);
    bit x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); v[i] = x; end
    bit_out(nack);
  endtask

  task automatic wr_txn(input int d, input int a, input int n);
    bit ack;
    logic [7:0] v;
    int pa;
    do_start;
    send(dev_byte(d, a, 1'b0), ack); check(ack, "R2 R5 device ack on write", ack, 1);
    send(8'(a), ack);                check(ack, "R5 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      v = 8'($urandom);
      send(v, ack); check(ack, "R5 data ack", ack, 1);
      pa = (a & ~15) | ((a + k) & 15);
      exp_m[d][pa] = v;
    end
    do_stop;
  endtask

  task automatic rd_txn(input int d, input int a, input int n);
    bit ack;
    logic [7:0] v;
    int ea;
    do_start;
    send(dev_byte(d, a, 1'b0), ack); check(ack, "R8 dummy write ack", ack, 1);
    send(8'(a), ack);                check(ack, "R8 word address ack", ack, 1);
    do_start;
    send(dev_byte(d, a, 1'b1), ack); check(ack, "R8 read device ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv(v, k == n - 1);
      ea = (a + k) % dsize(d);
      check(v == exp_m[d][ea], "R8 R2 read data", v, exp_m[d][ea]);
    end
    do_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    int c0, c1, d, a, n;
    void'($urandom(32'h5eed1234));
    for (int dd = 0; dd < 2; dd++)
      for (int i = 0; i < 512; i++) exp_m[dd][i] = 8'((i * 37 + 11) & 255);

    hq(5); rst_n = 1'b1; hq(5);
    check(!pull_a && !pull_b, "R4 reset releases SDA", {pull_a, pull_b}, 0);
    check(!wen_a && !com_a && !wen_b && !com_b, "R5 R7 reset strobes low",
          {wen_a, com_a, wen_b, com_b}, 0);

    // R1: wrong device type nibble
    do_start; send(8'b1011_1010, ack); do_stop;
    check(!ack, "R1 wrong type nibble not acked", ack, 0);
    check(!pull_a && !pull_b, "R1 SDA released after miss", {pull_a, pull_b}, 0);

    // R2: strap mismatch for both devices
    do_start; send(8'b1010_1000, ack); do_stop;
    check(!ack, "R2 strap mismatch not acked", ack, 0);

    // R5 R7 R3: byte write then busy poll
    c0 = cm_a;
    wr_txn(0, 8'h3C, 1);
    hq(4);
    check(cm_a == c0 + 1, "R7 commit after byte write", cm_a, c0 + 1);
    do_start; send(dev_byte(0, 0, 1'b0), ack); do_stop;
    check(!ack, "R3 busy device stays silent", ack, 0);
    hq(BUSY_CYC + 60);
    do_start; send(dev_byte(0, 0, 1'b0), ack); do_stop;
    check(ack, "R3 ack after busy ends", ack, 1);
    hq(4);
    check(cm_a == c0 + 1, "R7 no commit without data", cm_a, c0 + 1);
    rd_txn(0, 8'h3C, 1);

    // R7: word address only, then stop
    c1 = cm_b;
    do_start; send(dev_byte(1, 9'h120, 1'b0), ack); send(8'h20, ack); do_stop;
    hq(4);
    check(cm_b == c1, "R7 address-only write gives no commit", cm_b, c1);

    // R2: block select bit on 4 Kbit device
    wr_txn(1, 9'h1F5, 2);
    hq(BUSY_CYC + 60);
    rd_txn(1, 9'h1F5, 2);
    rd_txn(1, 9'h0F5, 2);

    // R6: 20-byte burst wraps in page
    wr_txn(0, 8'h2E, 20);
    hq(BUSY_CYC + 60);
    rd_txn(0, 8'h20, 16);

    // R8: read wraps past array end, then current-address read
    rd_txn(0, 8'hFE, 3);
    do_start; send(dev_byte(0, 0, 1'b1), ack);
    check(ack, "R8 current address read ack", ack, 1);
    recv(v, 1'b1); do_stop;
    check(v == exp_m[0][1], "R8 current address follows pointer", v, exp_m[0][1]);
    check(!pull_a, "R8 SDA released after nack", pull_a, 0);

    // R9: start in middle of device byte and of word address
    do_start; bit_out(1); bit_out(0); bit_out(1); bit_out(0);
    do_start; send(dev_byte(0, 0, 1'b0), ack);
    check(ack, "R9 restart mid device byte", ack, 1);
    bit_out(0); bit_out(1); bit_out(1);
    do_start; send(dev_byte(1, 0, 1'b1), ack);
    check(ack, "R9 restart mid word address", ack, 1);
    recv(v, 1'b1); do_stop;
    check(!pull_b, "R9 SDA released after read", pull_b, 0);

    // random writes and read-back
    for (int t = 0; t < 10; t++) begin
      d = int'($urandom % 2);
      a = int'($urandom % dsize(d));
      n = 1 + int'($urandom % 4);
      wr_txn(d, a, n);
      hq(BUSY_CYC + 60);
      rd_txn(d, a & ~15, 3);
      rd_txn(d, a, 2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule